// File: doc/BRIEF.md
# Bus Fault Event Merger

This block gathers the error strobes that several bus integrity checkers raise: an AXI master, an AXI slave, an AXI peripheral port and an AHB peripheral port. It merges them into two single-bit events for a system event bus, one for correctable faults and one for fatal faults. It also drives two saturating fault counters that a performance monitor reads. The checkers compute the syndromes. This block sees only finished strobes and transfer addresses.

A single report register holds the address of the most recent correctable fault on one of the address-reporting ports: the AXI master, the AXI peripheral port or the AHB peripheral port. The address is kept at doubleword granularity. When more than one of these ports reports in the same cycle, a fixed priority picks the address. The per-channel fatal strobes are also passed out as registered raw status, alongside the merged fatal event. All outputs are registered and appear one clock after the strobes that cause them.

Top module: `bus_fault_merge`

## Requirements
- R1: `evt_corr_o` is high in the cycle after any of `mst_corr_i`, `slv_corr_i`, `paxi_corr_i`, `pahb_corr_i` is high, as one pulse however many sources are active, and low after a cycle with none.
- R2: `evt_fatal_o` is high in the cycle after any bit of any fatal input is high, and low after a cycle with none.
- R3: `corr_cnt_o` grows by exactly 1, and is visible together with `evt_corr_o`, for each cycle with one or more correctable strobes.
- R4: `fatal_cnt_o` grows by exactly 1 for each cycle with one or more fatal strobes.
- R5: Both counters stop at the all-ones value of `CNT_W` bits and do not wrap.
- R6: `cnt_clr_i` sets both counters to 0 on the next edge. It takes priority over any increment in the same cycle and has no effect on the events.
- R7: The address-report priority is master, then AXI peripheral, then AHB peripheral. `slv_corr_i` never affects the address report.
- R8: `caddr_o` is the selected address with its three lowest bits dropped, that is `addr[ADDR_W-1:3]`.
- R9: `caddr_vld_o` pulses for one cycle after a cycle with a selected correctable strobe. `caddr_o` holds its value in all other cycles.
- R10: `fatal_stat_o` is the registered raw fatal strobes, packed as bits `[AXI_CH-1:0]` master, `[2*AXI_CH-1:AXI_CH]` slave, `[3*AXI_CH-1:2*AXI_CH]` AXI peripheral, and bit `3*AXI_CH` AHB peripheral.
- R11: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| mst_corr_i | input | 1 | AXI master correctable strobe |
| mst_addr_i | input | ADDR_W | AXI master transfer address |
| slv_corr_i | input | 1 | AXI slave correctable strobe |
| paxi_corr_i | input | 1 | AXI peripheral correctable strobe |
| paxi_addr_i | input | ADDR_W | AXI peripheral transfer address |
| pahb_corr_i | input | 1 | AHB peripheral correctable strobe |
| pahb_addr_i | input | ADDR_W | AHB peripheral transfer address |
| mst_fatal_i | input | AXI_CH | AXI master fatal strobes, one per channel |
| slv_fatal_i | input | AXI_CH | AXI slave fatal strobes, one per channel |
| paxi_fatal_i | input | AXI_CH | AXI peripheral fatal strobes, one per channel |
| pahb_fatal_i | input | 1 | AHB peripheral fatal strobe |
| evt_corr_o | output | 1 | Merged correctable event |
| evt_fatal_o | output | 1 | Merged fatal event |
| fatal_stat_o | output | 3*AXI_CH+1 | Registered raw fatal strobes |
| caddr_vld_o | output | 1 | Address report update pulse |
| caddr_o | output | ADDR_W-3 | Reported doubleword address |
| corr_cnt_o | output | CNT_W | Correctable fault counter |
| fatal_cnt_o | output | CNT_W | Fatal fault counter |

## Verification
The bound checker checks these properties on every cycle: the event-to-strobe relation, the single-step counter increment, saturation, clear priority, master priority, the absence of a report pulse when no strobe is present, and address hold. The bench scenarios are needed for the rest. They sweep every combination of correctable strobes and every fatal bit pattern. They confirm the AXI-over-AHB peripheral order and that the slave leaves the address untouched. They also check the bit packing of the raw fatal status, which no single-port property fully captures.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MST  = 2'd1,
    SRC_PAXI = 2'd2,
    SRC_PAHB = 2'd3
  } addr_src_e;
endpackage

// File: rtl/bfm_merge.sv
module bfm_merge #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic         any_o
);
  always_comb begin
    any_o = 1'b0;
    for (int i = 0; i < N; i++) any_o = any_o | req_i[i];
  end
endmodule

// File: rtl/bfm_addr_sel.sv
module bfm_addr_sel
  import bfm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned DW_W  = ADDR_W - 3
) (
  input  logic              mst_i,
  input  logic [ADDR_W-1:0] mst_addr_i,
  input  logic              paxi_i,
  input  logic [ADDR_W-1:0] paxi_addr_i,
  input  logic              pahb_i,
  input  logic [ADDR_W-1:0] pahb_addr_i,
  output addr_src_e         src_o,
  output logic [DW_W-1:0]   dw_addr_o
);
  logic [ADDR_W-1:0] sel_addr;
  logic              unused_lo;

  always_comb begin
    if (mst_i)       src_o = SRC_MST;
    else if (paxi_i) src_o = SRC_PAXI;
    else if (pahb_i) src_o = SRC_PAHB;
    else             src_o = SRC_NONE;
  end

  always_comb begin
    unique case (src_o)
      SRC_MST:  sel_addr = mst_addr_i;
      SRC_PAXI: sel_addr = paxi_addr_i;
      SRC_PAHB: sel_addr = pahb_addr_i;
      default:  sel_addr = '0;
    endcase
  end

  // doubleword granularity
  assign dw_addr_o = sel_addr[ADDR_W-1:3];
  assign unused_lo = ^sel_addr[2:0];
endmodule

// File: rtl/bfm_sat_cnt.sv
module bfm_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bus_fault_merge.sv
module bus_fault_merge
  import bfm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned AXI_CH = 5,
  localparam int unsigned DW_W  = ADDR_W - 3,
  localparam int unsigned FAT_W = 3 * AXI_CH + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_clr_i,
  input  logic              mst_corr_i,
  input  logic [ADDR_W-1:0] mst_addr_i,
  input  logic              slv_corr_i,
  input  logic              paxi_corr_i,
  input  logic [ADDR_W-1:0] paxi_addr_i,
  input  logic              pahb_corr_i,
  input  logic [ADDR_W-1:0] pahb_addr_i,
  input  logic [AXI_CH-1:0] mst_fatal_i,
  input  logic [AXI_CH-1:0] slv_fatal_i,
  input  logic [AXI_CH-1:0] paxi_fatal_i,
  input  logic              pahb_fatal_i,
  output logic              evt_corr_o,
  output logic              evt_fatal_o,
  output logic [FAT_W-1:0]  fatal_stat_o,
  output logic              caddr_vld_o,
  output logic [DW_W-1:0]   caddr_o,
  output logic [CNT_W-1:0]  corr_cnt_o,
  output logic [CNT_W-1:0]  fatal_cnt_o
);
  logic [3:0]       corr_vec;
  logic [FAT_W-1:0] fat_vec;
  logic             corr_any, fat_any;
  addr_src_e        src;
  logic [DW_W-1:0]  dw_addr;
  logic [1:0]       inc;
  logic [CNT_W-1:0] cnt [2];

  assign corr_vec = {pahb_corr_i, paxi_corr_i, slv_corr_i, mst_corr_i};
  assign fat_vec  = {pahb_fatal_i, paxi_fatal_i, slv_fatal_i, mst_fatal_i};

  bfm_merge #(.N(4)) u_corr_merge (.req_i(corr_vec), .any_o(corr_any));
  bfm_merge #(.N(FAT_W)) u_fat_merge (.req_i(fat_vec), .any_o(fat_any));

  bfm_addr_sel #(.ADDR_W(ADDR_W)) u_addr_sel (
    .mst_i      (mst_corr_i),
    .mst_addr_i (mst_addr_i),
    .paxi_i     (paxi_corr_i),
    .paxi_addr_i(paxi_addr_i),
    .pahb_i     (pahb_corr_i),
    .pahb_addr_i(pahb_addr_i),
    .src_o      (src),
    .dw_addr_o  (dw_addr)
  );

  assign inc = {fat_any, corr_any};

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    bfm_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (cnt_clr_i),
      .inc_i (inc[k]),
      .cnt_o (cnt[k])
    );
  end

  assign corr_cnt_o  = cnt[0];
  assign fatal_cnt_o = cnt[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_corr_o   <= 1'b0;
      evt_fatal_o  <= 1'b0;
      fatal_stat_o <= '0;
      caddr_vld_o  <= 1'b0;
    end else begin
      evt_corr_o   <= corr_any;
      evt_fatal_o  <= fat_any;
      fatal_stat_o <= fat_vec;
      caddr_vld_o  <= (src != SRC_NONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               caddr_o <= '0;
    else if (src != SRC_NONE)  caddr_o <= dw_addr;
  end
endmodule

// File: rtl/bus_fault_merge_chk.sv
module bus_fault_merge_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned AXI_CH = 5,
  localparam int unsigned DW_W  = ADDR_W - 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_clr_i,
  input logic              mst_corr_i,
  input logic [ADDR_W-1:0] mst_addr_i,
  input logic              slv_corr_i,
  input logic              paxi_corr_i,
  input logic              pahb_corr_i,
  input logic [AXI_CH-1:0] mst_fatal_i,
  input logic [AXI_CH-1:0] slv_fatal_i,
  input logic [AXI_CH-1:0] paxi_fatal_i,
  input logic              pahb_fatal_i,
  input logic              evt_corr_o,
  input logic              evt_fatal_o,
  input logic              caddr_vld_o,
  input logic [DW_W-1:0]   caddr_o,
  input logic [CNT_W-1:0]  corr_cnt_o,
  input logic [CNT_W-1:0]  fatal_cnt_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  logic c_any, f_any, a_any;
  assign c_any = mst_corr_i | slv_corr_i | paxi_corr_i | pahb_corr_i;
  assign f_any = (|mst_fatal_i) | (|slv_fatal_i) | (|paxi_fatal_i) | pahb_fatal_i;
  assign a_any = mst_corr_i | paxi_corr_i | pahb_corr_i;

  AST_CORR_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_any |=> evt_corr_o); // R1
  AST_CORR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_any |=> !evt_corr_o); // R1
  AST_FATAL_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_any |=> evt_fatal_o); // R2
  AST_CORR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_any && !cnt_clr_i && corr_cnt_o != MAX) |=> corr_cnt_o == $past(corr_cnt_o) + 1'b1); // R3
  AST_FATAL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_any && !cnt_clr_i && fatal_cnt_o != MAX) |=> fatal_cnt_o == $past(fatal_cnt_o) + 1'b1); // R4
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && corr_cnt_o == MAX) |=> corr_cnt_o == MAX); // R5
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (corr_cnt_o == '0 && fatal_cnt_o == '0)); // R6
  AST_MST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_corr_i |=> (caddr_vld_o && caddr_o == $past(mst_addr_i[ADDR_W-1:3]))); // R7
  AST_NO_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_any |=> !caddr_vld_o); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !caddr_vld_o |-> $stable(caddr_o)); // R9
endmodule

bind bus_fault_merge bus_fault_merge_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .AXI_CH(AXI_CH)
) u_chk (.*);

// File: tb/bus_fault_merge_test.sv
module bus_fault_merge_test;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned AXI_CH = 2;
  localparam int unsigned DW_W   = ADDR_W - 3;
  localparam int unsigned FAT_W  = 3 * AXI_CH + 1;
  localparam int unsigned CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic mc = 1'b0, sc = 1'b0, pxc = 1'b0, phc = 1'b0;
  logic [ADDR_W-1:0] ma = '0, pxa = '0, pha = '0;
  logic [AXI_CH-1:0] mf = '0, sf = '0, pxf = '0;
  logic phf = 1'b0;
  logic evc, evf, avld;
  logic [FAT_W-1:0] fstat;
  logic [DW_W-1:0] caddr;
  logic [CNT_W-1:0] ccnt, fcnt;

  int checks = 0, errors = 0;
  int e_ccnt = 0, e_fcnt = 0, e_addr = 0;

  always #2.5 clk = ~clk;

  bus_fault_merge #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .AXI_CH(AXI_CH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clr_i(clr),
    .mst_corr_i(mc), .mst_addr_i(ma), .slv_corr_i(sc),
    .paxi_corr_i(pxc), .paxi_addr_i(pxa), .pahb_corr_i(phc), .pahb_addr_i(pha),
    .mst_fatal_i(mf), .slv_fatal_i(sf), .paxi_fatal_i(pxf), .pahb_fatal_i(phf),
    .evt_corr_o(evc), .evt_fatal_o(evf), .fatal_stat_o(fstat),
    .caddr_vld_o(avld), .caddr_o(caddr), .corr_cnt_o(ccnt), .fatal_cnt_o(fcnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // corr = {pahb, paxi, slv, mst}; fat = {pahb, paxi, slv, mst} packed like R10
  task automatic step(input logic [3:0] corr, input logic [FAT_W-1:0] fat, input bit c);
    bit ca, fa, av;
    int sel;
    mc = corr[0]; sc = corr[1]; pxc = corr[2]; phc = corr[3];
    {phf, pxf, sf, mf} = fat;
    clr = c;
    ca = |corr; fa = |fat; av = corr[0] | corr[2] | corr[3];
    sel = corr[0] ? int'(ma) : corr[2] ? int'(pxa) : int'(pha);
    if (av) e_addr = sel >> 3;
    if (c) begin e_ccnt = 0; e_fcnt = 0; end
    else begin
      if (ca && e_ccnt < CMAX) e_ccnt++;
      if (fa && e_fcnt < CMAX) e_fcnt++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(evc == ca, "R1", int'(evc), int'(ca));
    chk(evf == fa, "R2", int'(evf), int'(fa));
    chk(int'(ccnt) == e_ccnt, "R3/R5/R6 corr_cnt", int'(ccnt), e_ccnt);
    chk(int'(fcnt) == e_fcnt, "R4/R5/R6 fatal_cnt", int'(fcnt), e_fcnt);
    chk(avld == av, "R9 vld", int'(avld), int'(av));
    chk(int'(caddr) == e_addr, "R7/R8 caddr", int'(caddr), e_addr);
    chk(fstat == fat, "R10", int'(fstat), int'(fat));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(evc == 0 && evf == 0 && avld == 0, "R11 events", int'({evc, evf, avld}), 0);
    chk(caddr == '0 && ccnt == '0 && fcnt == '0 && fstat == '0, "R11 data", int'(caddr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R5 R7 R8 R9: all correctable combinations, idle between for hold check
    for (int r = 0; r < 2; r++) begin
      step(4'h0, '0, 1'b1);
      for (int c = 0; c < 16; c++) begin
        ma  = ADDR_W'(12'h800 + c * 8 + r * 3 + 1);
        pxa = ADDR_W'(12'h400 + c * 16 + 5);
        pha = ADDR_W'(12'h200 + c * 24 + 7);
        step(c[3:0], '0, 1'b0);
        ma = '1; pxa = '1; pha = '1;
        step(4'h0, '0, 1'b0);
      end
    end
    // R5: corr counter held at max after repeated hits
    for (int i = 0; i < 4; i++) step(4'h2, '0, 1'b0);

    // R2 R4 R10: every fatal bit pattern
    step(4'h0, '0, 1'b1);
    for (int f = 0; f < (1 << FAT_W); f++) begin
      step(4'h0, FAT_W'(f), 1'b0);
      if (f < 20) step(4'h0, '0, 1'b0);
    end

    // R6: clear beats concurrent increments, events still fire
    step(4'hF, '1, 1'b1);
    step(4'h1, 7'h01, 1'b0);
    // R7: slave alone leaves address untouched
    ma = 12'hFF8;
    step(4'h1, '0, 1'b0);
    step(4'h2, '0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule